// File: doc/BRIEF.md
# Command Queue Entry Decoder

This block takes one 128-bit command entry from a translation unit's command queue. The entry arrives as four 32-bit words under a valid/ready handshake. The block classifies the opcode in the low byte of the first word against a sparse map of legal codes. For a legal entry it registers the fields that the command class carries. One cycle after acceptance it pulses a completion strobe.

Where a field is located depends on the opcode. Fields that belong only to certain classes are driven to zero for every other class. These are the invalidation range, the range count and scale, the sync completion mode, and the resume controls. As a result, a downstream consumer never sees a stale or aliased value.

An entry with an opcode outside the legal set is consumed, but it is not decoded. The block records an illegal-command error and halts. The ready output stays low until the error is cleared with a one-cycle clear input. A sync entry that asks for interrupt completion raises a one-cycle interrupt pulse alongside the completion strobe.

Top module: `cmdq_entry_decoder`

## Requirements
- R1: The opcode is word0[7:0]. The legal codes and their class_o values are:
  - 0x01 and 0x02 give 1 (prefetch).
  - 0x03 to 0x07 give 2 (configuration invalidation).
  - 0x10 to 0x13, 0x18, 0x1A, 0x20 to 0x23, 0x28, 0x2A and 0x30 give 3 (TLB invalidation).
  - 0x40 gives 4, 0x41 gives 5, 0x44 gives 6 (resume), 0x45 gives 7 and 0x46 gives 8 (sync).
  - After reset, class_o is 0.
- R2: An entry is accepted on a rising edge where cmd_valid_i and cmd_ready_o are both high. For a legal entry, done_o is high for exactly the one cycle after that edge, and the decoded outputs change in that same cycle.
- R3: sid_o is all of word1. vmid_o is word1[15:0] and asid_o is word1[31:16]. ssid_o is word0[31:12] and ssv_o is word0[11].
- R4: addr_o is {word3, word2[31:12], 12'h000}. leaf_o is word2[0], ttl_o is word2[9:8] and tg_o is word2[11:10].
- R5: range_o is word2[4:0] only for opcode 0x04, and 0 for every other opcode.
- R6: num_o is word0[16:12] and scale_o is word0[24:20] for class 3 only. For every other class both are 0.
- R7: sync_cs_o is word0[13:12] for class 8 only, and 0 otherwise. When a sync entry with word0[13:12]=1 is accepted, irq_o pulses in the done_o cycle. No other entry raises irq_o.
- R8: For class 6 only, resume_retry_o is word0[12], resume_abort_o is word0[13] and stag_o is word2[15:0]. For every other class these outputs are 0.
- R9: Accepting an entry with an illegal opcode has four effects from the next cycle:
  - err_code_o becomes 1 and halt_o goes high.
  - cmd_ready_o goes low.
  - done_o stays low.
  - Every decoded output keeps its value.

  While halted, entries presented on the inputs are not accepted.
- R10: A clear_i pulse sampled while halted returns halt_o to 0, err_code_o to 0 and cmd_ready_o to 1 in the next cycle.
- R11: After reset, cmd_ready_o is 1, and done_o, irq_o, halt_o, err_code_o and all decoded outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Entry words are valid |
| cmd_ready_o | output | 1 | Decoder can accept an entry |
| cmd_w0_i | input | 32 | Entry word 0 |
| cmd_w1_i | input | 32 | Entry word 1 |
| cmd_w2_i | input | 32 | Entry word 2 |
| cmd_w3_i | input | 32 | Entry word 3 |
| clear_i | input | 1 | Releases the halt and clears the error |
| done_o | output | 1 | One-cycle pulse after a legal entry is accepted |
| irq_o | output | 1 | One-cycle pulse for a sync entry requesting an interrupt |
| halt_o | output | 1 | Consumption halted by an error |
| err_code_o | output | 2 | 0 none, 1 illegal command |
| opcode_o | output | 8 | Opcode of the last legal entry |
| class_o | output | 4 | Class of the last legal entry |
| sid_o | output | 32 | Stream identifier |
| vmid_o | output | 16 | Virtual machine identifier |
| asid_o | output | 16 | Address space identifier |
| ssid_o | output | 20 | Substream identifier |
| ssv_o | output | 1 | Substream identifier valid |
| addr_o | output | 64 | Target address |
| leaf_o | output | 1 | Leaf-only flag |
| ttl_o | output | 2 | Translation table level hint |
| tg_o | output | 2 | Translation granule |
| range_o | output | 5 | Invalidation range size |
| num_o | output | 5 | Range invalidation count |
| scale_o | output | 5 | Range invalidation scale |
| sync_cs_o | output | 2 | Sync completion mode |
| resume_retry_o | output | 1 | Resume retry/abort control |
| resume_abort_o | output | 1 | Resume abort |
| stag_o | output | 16 | Stall tag |

## Verification
The bench probes the edges of the opcode map. It sends the codes just inside the map (0x07, 0x1A, 0x2A, 0x30, 0x45) and the gaps just outside it (0x00, 0x08, 0x19, 0x2B, 0x47). A decoder with a range check that is off by one would halt on a legal command, or would decode garbage in a gap.

The bench also sends entries whose overlapping bit fields are all non-zero under the wrong class. This catches field gating that is missing or misrouted, which would leak count, range or resume values into unrelated commands. Sync entries are sent with both interrupt and non-interrupt completion, to catch an interrupt raised for the wrong mode.

Finally, the bench keeps valid asserted while the block is halted. A decoder that accepted entries during a halt, or that lost its error on that traffic, would show a done pulse or changed fields.

// File: rtl/cmdq_dec_pkg.sv
package cmdq_dec_pkg;
  localparam int WORD_W  = 32;
  localparam int OPC_W   = 8;
  localparam int ADDR_W  = 2 * WORD_W;
  localparam int PAGE_SH = 12;
  localparam int SSID_W  = WORD_W - PAGE_SH;
  localparam int HALF_W  = WORD_W / 2;
  localparam int SEL_W   = 5;
  localparam int ERR_W   = 2;

  localparam logic [OPC_W-1:0] OPC_CFG_RANGE = 8'h04;
  localparam logic [ERR_W-1:0] ERR_NONE = 2'd0;
  localparam logic [ERR_W-1:0] ERR_ILL  = 2'd1;
  localparam logic [1:0]       CS_IRQ   = 2'd1;

  typedef enum logic [3:0] {
    CLS_NONE     = 4'd0,
    CLS_PREFETCH = 4'd1,
    CLS_CFG_INV  = 4'd2,
    CLS_TLB_INV  = 4'd3,
    CLS_ATC_INV  = 4'd4,
    CLS_PRI_RESP = 4'd5,
    CLS_RESUME   = 4'd6,
    CLS_STALL_TM = 4'd7,
    CLS_SYNC     = 4'd8
  } cmd_class_e;

  typedef struct packed {
    logic [OPC_W-1:0]  opcode;
    cmd_class_e        cls;
    logic [WORD_W-1:0] sid;
    logic [HALF_W-1:0] vmid;
    logic [HALF_W-1:0] asid;
    logic [SSID_W-1:0] ssid;
    logic              ssv;
    logic [ADDR_W-1:0] addr;
    logic              leaf;
    logic [1:0]        ttl;
    logic [1:0]        tg;
    logic [SEL_W-1:0]  range_sz;
    logic [SEL_W-1:0]  num;
    logic [SEL_W-1:0]  scale;
    logic [1:0]        sync_cs;
    logic              res_retry;
    logic              res_abort;
    logic [HALF_W-1:0] stag;
  } cmd_fields_t;
endpackage

// File: rtl/cmdq_opc_class.sv
module cmdq_opc_class
  import cmdq_dec_pkg::*;
(
  input  logic [OPC_W-1:0] opc_i,
  output logic             legal_o,
  output cmd_class_e       cls_o
);
  always_comb begin
    legal_o = 1'b1;
    unique case (opc_i)
      8'h01, 8'h02:                       cls_o = CLS_PREFETCH;
      8'h03, 8'h04, 8'h05, 8'h06, 8'h07:  cls_o = CLS_CFG_INV;
      8'h10, 8'h11, 8'h12, 8'h13, 8'h18, 8'h1A,
      8'h20, 8'h21, 8'h22, 8'h23, 8'h28, 8'h2A,
      8'h30:                              cls_o = CLS_TLB_INV;
      8'h40:                              cls_o = CLS_ATC_INV;
      8'h41:                              cls_o = CLS_PRI_RESP;
      8'h44:                              cls_o = CLS_RESUME;
      8'h45:                              cls_o = CLS_STALL_TM;
      8'h46:                              cls_o = CLS_SYNC;
      default: begin
        cls_o   = CLS_NONE;
        legal_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/cmdq_field_extract.sv
module cmdq_field_extract
  import cmdq_dec_pkg::*;
(
  input  logic [WORD_W-1:0] w0_i,
  input  logic [WORD_W-1:0] w1_i,
  input  logic [WORD_W-1:0] w2_i,
  input  logic [WORD_W-1:0] w3_i,
  input  cmd_class_e        cls_i,
  output cmd_fields_t       f_o
);
  logic is_tlb, is_sync, is_res, is_rng;
  logic [OPC_W-1:0] opc;

  assign opc     = w0_i[OPC_W-1:0];
  assign is_tlb  = (cls_i == CLS_TLB_INV);
  assign is_sync = (cls_i == CLS_SYNC);
  assign is_res  = (cls_i == CLS_RESUME);
  assign is_rng  = (opc == OPC_CFG_RANGE);

  logic unused_bits;
  assign unused_bits = ^{w0_i[10:8], w0_i[31:25], w0_i[19:17], w2_i[7:5]};

  always_comb begin
    f_o           = '0;
    f_o.opcode    = opc;
    f_o.cls       = cls_i;
    f_o.sid       = w1_i;
    f_o.vmid      = w1_i[HALF_W-1:0];
    f_o.asid      = w1_i[WORD_W-1:HALF_W];
    f_o.ssid      = w0_i[WORD_W-1:PAGE_SH];
    f_o.ssv       = w0_i[11];
    f_o.addr      = {w3_i, w2_i[WORD_W-1:PAGE_SH], {PAGE_SH{1'b0}}};
    f_o.leaf      = w2_i[0];
    f_o.ttl       = w2_i[9:8];
    f_o.tg        = w2_i[11:10];
    // class-dependent fields overlap other fields; gate to zero elsewhere
    f_o.range_sz  = is_rng  ? w2_i[SEL_W-1:0] : '0;
    f_o.num       = is_tlb  ? w0_i[16:12]     : '0;
    f_o.scale     = is_tlb  ? w0_i[24:20]     : '0;
    f_o.sync_cs   = is_sync ? w0_i[13:12]     : '0;
    f_o.res_retry = is_res  & w0_i[12];
    f_o.res_abort = is_res  & w0_i[13];
    f_o.stag      = is_res  ? w2_i[HALF_W-1:0] : '0;
  end
endmodule

// File: rtl/cmdq_halt_ctrl.sv
module cmdq_halt_ctrl
  import cmdq_dec_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             illegal_acc_i,
  input  logic             clear_i,
  output logic             halt_o,
  output logic [ERR_W-1:0] err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halt_o <= 1'b0;
      err_o  <= ERR_NONE;
    end else if (illegal_acc_i) begin
      halt_o <= 1'b1;
      err_o  <= ERR_ILL;
    end else if (clear_i) begin
      halt_o <= 1'b0;
      err_o  <= ERR_NONE;
    end
  end

  assert_halt_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_acc_i |=> (halt_o && err_o == ERR_ILL));
  assert_halt_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_o && !clear_i) |=> halt_o);
  assert_clear_release_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && !illegal_acc_i) |=> (!halt_o && err_o == ERR_NONE));
endmodule

// File: rtl/cmdq_entry_decoder.sv
module cmdq_entry_decoder
  import cmdq_dec_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [WORD_W-1:0] cmd_w0_i,
  input  logic [WORD_W-1:0] cmd_w1_i,
  input  logic [WORD_W-1:0] cmd_w2_i,
  input  logic [WORD_W-1:0] cmd_w3_i,
  input  logic              clear_i,
  output logic              done_o,
  output logic              irq_o,
  output logic              halt_o,
  output logic [ERR_W-1:0]  err_code_o,
  output logic [OPC_W-1:0]  opcode_o,
  output logic [3:0]        class_o,
  output logic [WORD_W-1:0] sid_o,
  output logic [HALF_W-1:0] vmid_o,
  output logic [HALF_W-1:0] asid_o,
  output logic [SSID_W-1:0] ssid_o,
  output logic              ssv_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              leaf_o,
  output logic [1:0]        ttl_o,
  output logic [1:0]        tg_o,
  output logic [SEL_W-1:0]  range_o,
  output logic [SEL_W-1:0]  num_o,
  output logic [SEL_W-1:0]  scale_o,
  output logic [1:0]        sync_cs_o,
  output logic              resume_retry_o,
  output logic              resume_abort_o,
  output logic [HALF_W-1:0] stag_o
);
  logic        legal, accept, legal_acc, illegal_acc;
  cmd_class_e  cls;
  cmd_fields_t fields_d, fields_q;

  cmdq_opc_class u_class (
    .opc_i   (cmd_w0_i[OPC_W-1:0]),
    .legal_o (legal),
    .cls_o   (cls)
  );

  cmdq_field_extract u_extract (
    .w0_i  (cmd_w0_i),
    .w1_i  (cmd_w1_i),
    .w2_i  (cmd_w2_i),
    .w3_i  (cmd_w3_i),
    .cls_i (cls),
    .f_o   (fields_d)
  );

  cmdq_halt_ctrl u_halt (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .illegal_acc_i (illegal_acc),
    .clear_i       (clear_i),
    .halt_o        (halt_o),
    .err_o         (err_code_o)
  );

  assign cmd_ready_o = !halt_o;
  assign accept      = cmd_valid_i && cmd_ready_o;
  assign legal_acc   = accept && legal;
  assign illegal_acc = accept && !legal;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fields_q <= '0;
      done_o   <= 1'b0;
      irq_o    <= 1'b0;
    end else begin
      done_o <= legal_acc;
      irq_o  <= legal_acc && (fields_d.sync_cs == CS_IRQ);
      if (legal_acc) fields_q <= fields_d;
    end
  end

  assign opcode_o       = fields_q.opcode;
  assign class_o        = fields_q.cls;
  assign sid_o          = fields_q.sid;
  assign vmid_o         = fields_q.vmid;
  assign asid_o         = fields_q.asid;
  assign ssid_o         = fields_q.ssid;
  assign ssv_o          = fields_q.ssv;
  assign addr_o         = fields_q.addr;
  assign leaf_o         = fields_q.leaf;
  assign ttl_o          = fields_q.ttl;
  assign tg_o           = fields_q.tg;
  assign range_o        = fields_q.range_sz;
  assign num_o          = fields_q.num;
  assign scale_o        = fields_q.scale;
  assign sync_cs_o      = fields_q.sync_cs;
  assign resume_retry_o = fields_q.res_retry;
  assign resume_abort_o = fields_q.res_abort;
  assign stag_o         = fields_q.stag;

  assert_done_src_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(cmd_valid_i && cmd_ready_o));
  assert_irq_src_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(cmd_valid_i && cmd_ready_o && cmd_w0_i[7:0] == 8'h46
                    && cmd_w0_i[13:12] == 2'd1));
  assert_no_done_illegal_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_acc |=> (!done_o && $stable(class_o) && $stable(addr_o)));
  assert_halted_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_o && $past(halt_o)) |-> !done_o);
endmodule

// File: tb/cmdq_entry_decoder_test.sv
module cmdq_entry_decoder_test;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic valid = 1'b0, clear = 1'b0;
  logic [31:0] w0 = '0, w1 = '0, w2 = '0, w3 = '0;
  logic ready, done, irq, halt, ssv, leaf, rretry, rabort;
  logic [1:0] err, ttl, tg, scs;
  logic [7:0] opc;
  logic [3:0] cls;
  logic [31:0] sid;
  logic [15:0] vmid, asid, stag;
  logic [19:0] ssid;
  logic [63:0] addr;
  logic [4:0] rng, num, scale;

  int total = 0, bad = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  cmdq_entry_decoder uut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(valid), .cmd_ready_o(ready),
    .cmd_w0_i(w0), .cmd_w1_i(w1), .cmd_w2_i(w2), .cmd_w3_i(w3), .clear_i(clear),
    .done_o(done), .irq_o(irq), .halt_o(halt), .err_code_o(err),
    .opcode_o(opc), .class_o(cls), .sid_o(sid), .vmid_o(vmid), .asid_o(asid),
    .ssid_o(ssid), .ssv_o(ssv), .addr_o(addr), .leaf_o(leaf), .ttl_o(ttl),
    .tg_o(tg), .range_o(rng), .num_o(num), .scale_o(scale), .sync_cs_o(scs),
    .resume_retry_o(rretry), .resume_abort_o(rabort), .stag_o(stag)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // present one entry for one edge; returns at the negedge after acceptance
  task automatic send(input logic [31:0] a, b, c, d);
    @(negedge clk);
    w0 = a; w1 = b; w2 = c; w3 = d; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic pulse_clear();
    @(negedge clk); clear = 1'b1;
    @(negedge clk); clear = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11 ready", ready, 1); chk("R11 done", done, 0); chk("R11 irq", irq, 0);
    chk("R11 halt", halt, 0); chk("R11 err", err, 0); chk("R11 class", cls, 0);
    chk("R11 addr", addr, 0); chk("R11 sid", sid, 0);
  endtask

  task automatic t_cfg_inv();
    send(32'hABCDE803, 32'h12345678, 32'h0000_0013, 32'h0);
    chk("R2 done", done, 1); chk("R1 class", cls, 2); chk("R1 opcode", opc, 8'h03);
    chk("R3 sid", sid, 32'h12345678); chk("R3 vmid", vmid, 16'h5678);
    chk("R3 asid", asid, 16'h1234); chk("R3 ssid", ssid, 20'hABCDE); chk("R3 ssv", ssv, 1);
    chk("R5 range gated", rng, 0); chk("R6 num gated", num, 0);
    @(negedge clk); chk("R2 done one cycle", done, 0);
  endtask

  task automatic t_range();
    send(32'h0000_0004, 32'h0, 32'hFFFF_F3F5, 32'h0);
    chk("R5 range", rng, 5'h15); chk("R1 class", cls, 2);
    chk("R8 stag gated", stag, 0);
  endtask

  task automatic t_tlb();
    send(32'h01A0_5012, 32'hCAFE_0042, 32'h8765_4B01, 32'h0000_00FE);
    chk("R1 class", cls, 3); chk("R4 addr", addr, 64'h0000_00FE_8765_4000);
    chk("R4 leaf", leaf, 1); chk("R4 ttl", ttl, 3); chk("R4 tg", tg, 2);
    chk("R6 num", num, 5'h05); chk("R6 scale", scale, 5'h1A);
    chk("R7 cs gated", scs, 0); chk("R5 range gated", rng, 0); chk("R7 no irq", irq, 0);
  endtask

  task automatic t_sync();
    send(32'h0000_1046, 32'h0, 32'h0, 32'h0);
    chk("R7 class", cls, 8); chk("R7 cs", scs, 1); chk("R7 irq", irq, 1);
    chk("R6 num gated", num, 0);
    @(negedge clk); chk("R7 irq one cycle", irq, 0);
    send(32'h0000_2046, 32'h0, 32'h0, 32'h0);
    chk("R7 cs sev", scs, 2); chk("R7 no irq sev", irq, 0); chk("R2 done", done, 1);
  endtask

  task automatic t_resume();
    send(32'h0000_3044, 32'h0, 32'hFFFF_BEEF, 32'h0);
    chk("R8 class", cls, 6); chk("R8 retry", rretry, 1); chk("R8 abort", rabort, 1);
    chk("R8 stag", stag, 16'hBEEF); chk("R7 cs gated", scs, 0);
    send(32'h0000_1044, 32'h0, 32'h0000_0123, 32'h0);
    chk("R8 retry", rretry, 1); chk("R8 abort", rabort, 0); chk("R8 stag", stag, 16'h0123);
    chk("R7 no irq", irq, 0);
    send(32'h0000_3045, 32'h0, 32'hFFFF_FFFF, 32'h0);
    chk("R8 gated stall", {rretry, rabort}, 0); chk("R8 stag gated", stag, 0);
    chk("R1 class", cls, 7);
  endtask

  task automatic t_illegal(input logic [7:0] code);
    send(32'h0000_3044, 32'h0, 32'h0000_5555, 32'h0);
    send({24'hFFFFF0, code}, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    chk("R9 no done", done, 0); chk("R9 halt", halt, 1); chk("R9 err", err, 1);
    chk("R9 ready low", ready, 0); chk("R9 class held", cls, 6);
    chk("R9 stag held", stag, 16'h5555);
    // entry presented while halted must not be taken
    @(negedge clk); w0 = 32'h0000_0003; valid = 1'b1;
    @(negedge clk); @(negedge clk); valid = 1'b0;
    chk("R9 halted no done", done, 0); chk("R9 halted class", cls, 6);
    chk("R9 still halted", halt, 1);
    pulse_clear();
    chk("R10 halt clear", halt, 0); chk("R10 err clear", err, 0); chk("R10 ready", ready, 1);
  endtask

  task automatic t_legal_edge(input logic [7:0] code, input logic [3:0] exp_cls);
    send({24'h0, code}, 32'h0, 32'h0, 32'h0);
    chk("R1 edge done", done, 1); chk("R1 edge class", cls, exp_cls);
    chk("R1 edge halt", halt, 0);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cfg_inv();
    t_range();
    t_tlb();
    t_sync();
    t_resume();
    t_illegal(8'h08);
    t_illegal(8'h00);
    t_illegal(8'h19);
    t_illegal(8'h2B);
    t_illegal(8'h47);
    t_legal_edge(8'h01, 4'd1);
    t_legal_edge(8'h07, 4'd2);
    t_legal_edge(8'h1A, 4'd3);
    t_legal_edge(8'h2A, 4'd3);
    t_legal_edge(8'h30, 4'd3);
    t_legal_edge(8'h40, 4'd4);
    t_legal_edge(8'h41, 4'd5);
    t_legal_edge(8'h45, 4'd7);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule